// File: doc/BRIEF.md
# UART Interrupt Identity and Priority Logic

This block sits beside the register file of a 16550-style serial port. It keeps one pending flag for each of six interrupt sources and picks the most urgent enabled one. It presents that source as a 4-bit identity code and drives a single interrupt line. The sources are receive line errors, receive data ready, character timeout, transmit holding empty, modem line change and an attempt to write the line control register while the port is busy. Each flag is raised by a one-cycle event (receive data in FIFO mode follows a level input instead). It is lowered by the register access that software uses to service it.

The surrounding port logic supplies the event pulses, the FIFO mode and trigger level, the busy flag, and one-cycle strobes for the register accesses. The serial shifters, FIFOs, baud timing and register storage all live outside the block. Pending flags are registered, so the identity code reflects an event from the clock edge after it is seen. Per-source enables only mask reporting: a masked source stays pending and is reported as soon as it is enabled.

Top module: `uart_int_ident`

## Requirements
- R1: After reset (active-low `rstN`) nothing is pending, `intId` is 0001 and `irq` is low.
- R2: `irq` is high exactly when `intId` differs from 0001.
- R3: Among enabled pending sources the reported one is chosen highest first: line status (0110), receive data (0100), character timeout (1100), transmit empty (0010), modem change (0000), busy write (0111).
- R4: A `lineErrEvt` pulse makes line status pending from the next cycle on, and an `lsrRead` strobe clears it.
- R5: With `fifoEn` low, receive data is set by `rxCharEvt` and cleared by `rbrRead`. With `fifoEn` high, it follows `rxAtTrig` one cycle later, and `rbrRead` has no effect on it.
- R6: A `rxTimeoutEvt` pulse makes character timeout pending, and `rbrRead` clears it.
- R7: Transmit empty is set by `threEvt`. It is cleared by `thrWrite`, or by `iirRead` only in a cycle where `intId` is 0010. An `iirRead` while another source is reported leaves it pending.
- R8: A `modemEvt` pulse makes modem change pending, and `msrRead` clears it.
- R9: `lcrWrite` with `busyFlag` high makes busy write pending. `lcrWrite` with `busyFlag` low is ignored. `usrRead` clears it.
- R10: `srcEn` bits map as follows: 0 line status, 1 receive data, 2 timeout, 3 transmit empty, 4 modem, 5 busy. A low bit hides that source from `intId` without clearing it.
- R11: When a set event and its clearing access arrive in the same cycle, the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcEn | input | 6 | Per-source report enables (bit map in R10) |
| fifoEn | input | 1 | FIFO mode selected |
| lineErrEvt | input | 1 | Overrun, parity, framing error or break seen |
| rxCharEvt | input | 1 | Character received (non-FIFO mode) |
| rxAtTrig | input | 1 | RX FIFO at or above trigger level (FIFO mode) |
| rxTimeoutEvt | input | 1 | Character timeout detected |
| threEvt | input | 1 | Holding register empty / TX FIFO at threshold |
| modemEvt | input | 1 | CTS, DSR, RI or DCD changed |
| busyFlag | input | 1 | Port currently busy |
| lcrWrite | input | 1 | Line control register write strobe |
| lsrRead | input | 1 | Line status register read strobe |
| rbrRead | input | 1 | Receive buffer read strobe |
| iirRead | input | 1 | Identity register read strobe |
| msrRead | input | 1 | Modem status register read strobe |
| usrRead | input | 1 | Port status register read strobe |
| thrWrite | input | 1 | Transmit holding / TX FIFO write strobe |
| intId | output | 4 | Identity code of the reported source |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the event and strobe inputs are single-cycle pulses that are synchronous to `clk` and held low while reset is active. They also assume that a clearing access checked against a source does not coincide with that source's own set event. The bench drives every pulse for exactly one cycle at the falling edge and releases it after the next rising edge. Same-cycle set and clear is applied only in the cycle dedicated to R11, where the related assertions are written to exclude it.

// File: rtl/uart_int_pkg.sv
package uart_int_pkg;

  localparam int NUM_SRC = 6;
  localparam int ID_W    = 4;

  // Source index, highest priority at the lowest index
  localparam int SRC_LS   = 0;
  localparam int SRC_RDA  = 1;
  localparam int SRC_TO   = 2;
  localparam int SRC_THRE = 3;
  localparam int SRC_MS   = 4;
  localparam int SRC_BUSY = 5;

  typedef enum logic [ID_W-1:0] {
    ID_MODEM   = 4'b0000,
    ID_NONE    = 4'b0001,
    ID_THRE    = 4'b0010,
    ID_RDA     = 4'b0100,
    ID_LINE    = 4'b0110,
    ID_BUSY    = 4'b0111,
    ID_TIMEOUT = 4'b1100
  } intId_e;

  // Strobes from control to the pending-flag datapath
  typedef struct packed {
    logic setBusy;
    logic clrLine;
    logic clrRda;
    logic clrTo;
    logic clrThre;
    logic clrMs;
    logic clrBusy;
  } ctlStrb_t;

  function automatic intId_e codeOf(input int idx);
    case (idx)
      SRC_LS:   codeOf = ID_LINE;
      SRC_RDA:  codeOf = ID_RDA;
      SRC_TO:   codeOf = ID_TIMEOUT;
      SRC_THRE: codeOf = ID_THRE;
      SRC_MS:   codeOf = ID_MODEM;
      SRC_BUSY: codeOf = ID_BUSY;
      default:  codeOf = ID_NONE;
    endcase
  endfunction

endpackage

// File: rtl/uart_int_src.sv
module uart_int_src
  import uart_int_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               fifoEn,
  input  logic               lineErrEvt,
  input  logic               rxCharEvt,
  input  logic               rxAtTrig,
  input  logic               rxTimeoutEvt,
  input  logic               threEvt,
  input  logic               modemEvt,
  input  ctlStrb_t           strb,
  output logic [NUM_SRC-1:0] pend
);

  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] clrVec;

  always_comb begin
    setVec           = '0;
    clrVec           = '0;
    setVec[SRC_LS]   = lineErrEvt;
    setVec[SRC_RDA]  = rxCharEvt;
    setVec[SRC_TO]   = rxTimeoutEvt;
    setVec[SRC_THRE] = threEvt;
    setVec[SRC_MS]   = modemEvt;
    setVec[SRC_BUSY] = strb.setBusy;
    clrVec[SRC_LS]   = strb.clrLine;
    clrVec[SRC_RDA]  = strb.clrRda;
    clrVec[SRC_TO]   = strb.clrTo;
    clrVec[SRC_THRE] = strb.clrThre;
    clrVec[SRC_MS]   = strb.clrMs;
    clrVec[SRC_BUSY] = strb.clrBusy;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    if (i == SRC_RDA) begin : g_rda
      // FIFO mode tracks the trigger level; otherwise set/clear like the rest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       pend[i] <= 1'b0;
        else if (fifoEn) pend[i] <= rxAtTrig;
        else             pend[i] <= setVec[i] | (pend[i] & ~clrVec[i]);
      end
    end else begin : g_evt
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pend[i] <= 1'b0;
        else       pend[i] <= setVec[i] | (pend[i] & ~clrVec[i]);
      end
    end
  end

endmodule

// File: rtl/uart_int_ctl.sv
module uart_int_ctl
  import uart_int_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic               fifoEn,
  input  logic               busyFlag,
  input  logic               lcrWrite,
  input  logic               lsrRead,
  input  logic               rbrRead,
  input  logic               iirRead,
  input  logic               msrRead,
  input  logic               usrRead,
  input  logic               thrWrite,
  output intId_e             curId,
  output ctlStrb_t           strb
);

  logic [NUM_SRC-1:0] live;
  assign live = pend & srcEn;

  // Walk from lowest to highest priority so the highest one wins
  always_comb begin
    curId = ID_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (live[i]) curId = codeOf(i);
    end
  end

  always_comb begin
    strb         = '0;
    strb.setBusy = lcrWrite & busyFlag;
    strb.clrLine = lsrRead;
    strb.clrRda  = rbrRead & ~fifoEn;
    strb.clrTo   = rbrRead;
    strb.clrThre = thrWrite | (iirRead & (curId == ID_THRE));
    strb.clrMs   = msrRead;
    strb.clrBusy = usrRead;
  end

endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
  import uart_int_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic               fifoEn,
  input  logic               lineErrEvt,
  input  logic               rxCharEvt,
  input  logic               rxAtTrig,
  input  logic               rxTimeoutEvt,
  input  logic               threEvt,
  input  logic               modemEvt,
  input  logic               busyFlag,
  input  logic               lcrWrite,
  input  logic               lsrRead,
  input  logic               rbrRead,
  input  logic               iirRead,
  input  logic               msrRead,
  input  logic               usrRead,
  input  logic               thrWrite,
  output logic [ID_W-1:0]    intId,
  output logic               irq
);

  logic [NUM_SRC-1:0] pend;
  ctlStrb_t           strb;
  intId_e             curId;

  uart_int_src u_src (
    .clk          (clk),
    .rstN         (rstN),
    .fifoEn       (fifoEn),
    .lineErrEvt   (lineErrEvt),
    .rxCharEvt    (rxCharEvt),
    .rxAtTrig     (rxAtTrig),
    .rxTimeoutEvt (rxTimeoutEvt),
    .threEvt      (threEvt),
    .modemEvt     (modemEvt),
    .strb         (strb),
    .pend         (pend)
  );

  uart_int_ctl u_ctl (
    .pend     (pend),
    .srcEn    (srcEn),
    .fifoEn   (fifoEn),
    .busyFlag (busyFlag),
    .lcrWrite (lcrWrite),
    .lsrRead  (lsrRead),
    .rbrRead  (rbrRead),
    .iirRead  (iirRead),
    .msrRead  (msrRead),
    .usrRead  (usrRead),
    .thrWrite (thrWrite),
    .curId    (curId),
    .strb     (strb)
  );

  assign intId = curId;
  assign irq   = (curId != ID_NONE);

endmodule

// File: rtl/uart_int_ident_chk.sv
module uart_int_ident_chk (
  input logic       clk,
  input logic       rstN,
  input logic [5:0] srcEn,
  input logic       lineErrEvt,
  input logic       rxTimeoutEvt,
  input logic       threEvt,
  input logic       modemEvt,
  input logic       busyFlag,
  input logic       lcrWrite,
  input logic       lsrRead,
  input logic       rbrRead,
  input logic       msrRead,
  input logic       usrRead,
  input logic       thrWrite,
  input logic [3:0] intId,
  input logic       irq
);

  a_r3_legal_code: assert property (@(posedge clk) disable iff (!rstN)
    intId inside {4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b0110, 4'b0111, 4'b1100});

  a_r2_quiet_line: assert property (@(posedge clk) disable iff (!rstN)
    (intId == 4'b0001) |-> !irq);

  a_r4_line_top: assert property (@(posedge clk) disable iff (!rstN)
    (lineErrEvt && srcEn[0]) |=> (!srcEn[0] || intId == 4'b0110));

  a_r4_line_clear: assert property (@(posedge clk) disable iff (!rstN)
    (lsrRead && !lineErrEvt) |=> (intId != 4'b0110));

  a_r6_timeout_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rbrRead && !rxTimeoutEvt) |=> (intId != 4'b1100));

  a_r7_thre_clear: assert property (@(posedge clk) disable iff (!rstN)
    (thrWrite && !threEvt) |=> (intId != 4'b0010));

  a_r8_modem_clear: assert property (@(posedge clk) disable iff (!rstN)
    (msrRead && !modemEvt) |=> (intId != 4'b0000));

  a_r9_busy_clear: assert property (@(posedge clk) disable iff (!rstN)
    (usrRead && !(lcrWrite && busyFlag)) |=> (intId != 4'b0111));

endmodule

bind uart_int_ident uart_int_ident_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .srcEn        (srcEn),
  .lineErrEvt   (lineErrEvt),
  .rxTimeoutEvt (rxTimeoutEvt),
  .threEvt      (threEvt),
  .modemEvt     (modemEvt),
  .busyFlag     (busyFlag),
  .lcrWrite     (lcrWrite),
  .lsrRead      (lsrRead),
  .rbrRead      (rbrRead),
  .msrRead      (msrRead),
  .usrRead      (usrRead),
  .thrWrite     (thrWrite),
  .intId        (intId),
  .irq          (irq)
);

// File: tb/sim_uart_int_ident.sv
`timescale 1ns/1ps
module sim_uart_int_ident;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] srcEn = 6'b111111;
  logic fifoEn = 0, lineErrEvt = 0, rxCharEvt = 0, rxAtTrig = 0, rxTimeoutEvt = 0;
  logic threEvt = 0, modemEvt = 0, busyFlag = 0, lcrWrite = 0;
  logic lsrRead = 0, rbrRead = 0, iirRead = 0, msrRead = 0, usrRead = 0, thrWrite = 0;
  logic [3:0] intId;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state: pending flags
  bit mLs, mRda, mTo, mThre, mMs, mBusy;

  always #5 clk = ~clk;

  uart_int_ident u0 (
    .clk(clk), .rstN(rstN), .srcEn(srcEn), .fifoEn(fifoEn),
    .lineErrEvt(lineErrEvt), .rxCharEvt(rxCharEvt), .rxAtTrig(rxAtTrig),
    .rxTimeoutEvt(rxTimeoutEvt), .threEvt(threEvt), .modemEvt(modemEvt),
    .busyFlag(busyFlag), .lcrWrite(lcrWrite), .lsrRead(lsrRead),
    .rbrRead(rbrRead), .iirRead(iirRead), .msrRead(msrRead),
    .usrRead(usrRead), .thrWrite(thrWrite), .intId(intId), .irq(irq)
  );

  function automatic logic [3:0] expId();
    if (mLs && srcEn[0])        return 4'b0110;
    else if (mRda && srcEn[1])  return 4'b0100;
    else if (mTo && srcEn[2])   return 4'b1100;
    else if (mThre && srcEn[3]) return 4'b0010;
    else if (mMs && srcEn[4])   return 4'b0000;
    else if (mBusy && srcEn[5]) return 4'b0111;
    else                        return 4'b0001;
  endfunction

  task automatic check(string tag, logic [3:0] e);
    checks++;
    if (intId !== e) begin
      errors++;
      $display("FAIL %s intId actual=%b expected=%b", tag, intId, e);
    end
    checks++;
    if (irq !== (e != 4'b0001)) begin
      errors++;
      $display("FAIL %s/R2 irq actual=%b expected=%b", tag, irq, (e != 4'b0001));
    end
  endtask

  // Inputs were set at the falling edge; check, advance model, release pulses
  task automatic tick(string tag);
    logic [3:0] e;
    bit nLs, nRda, nTo, nThre, nMs, nBusy;
    #1;
    e = expId();
    check(tag, e);
    nLs   = lineErrEvt | (mLs & !lsrRead);
    nRda  = fifoEn ? rxAtTrig : (rxCharEvt | (mRda & !rbrRead));
    nTo   = rxTimeoutEvt | (mTo & !rbrRead);
    nThre = threEvt | (mThre & !(thrWrite | (iirRead && e == 4'b0010)));
    nMs   = modemEvt | (mMs & !msrRead);
    nBusy = (lcrWrite & busyFlag) | (mBusy & !usrRead);
    @(posedge clk);
    {mLs, mRda, mTo, mThre, mMs, mBusy} = {nLs, nRda, nTo, nThre, nMs, nBusy};
    @(negedge clk);
    {lineErrEvt, rxCharEvt, rxTimeoutEvt, threEvt, modemEvt, lcrWrite} = '0;
    {lsrRead, rbrRead, iirRead, msrRead, usrRead, thrWrite} = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 4'b0001);
    rstN = 1'b1;
    tick("R1 after reset");

    // R4 line status set then cleared
    lineErrEvt = 1; tick("R4 set");
    tick("R4 pending");
    lsrRead = 1; tick("R4 clear");
    tick("R4 cleared");

    // R8 / R9 modem over busy
    modemEvt = 1; busyFlag = 1; lcrWrite = 1; tick("R9 set busy");
    tick("R3 modem over busy");
    msrRead = 1; tick("R8 clear");
    tick("R9 busy shown");
    usrRead = 1; tick("R9 clear");
    busyFlag = 0; lcrWrite = 1; tick("R9 write not busy");
    tick("R9 ignored");

    // R7 transmit empty
    threEvt = 1; tick("R7 set");
    iirRead = 1; tick("R7 iir read clears");
    tick("R7 cleared");
    threEvt = 1; modemEvt = 1; lineErrEvt = 1; tick("R3 triple set");
    iirRead = 1; tick("R7 iir read while line shown");
    lsrRead = 1; tick("R7 thre kept");
    tick("R3 thre over modem");
    thrWrite = 1; tick("R7 write clears");
    msrRead = 1; tick("R8 modem shown");
    tick("R8 cleared");

    // R5 / R6 receive data and timeout
    rxCharEvt = 1; rxTimeoutEvt = 1; tick("R5 set both");
    tick("R3 data before timeout");
    rbrRead = 1; tick("R6 read clears both");
    rxTimeoutEvt = 1; tick("R6 set");
    tick("R6 timeout shown");
    rbrRead = 1; tick("R6 clear");

    // R5 FIFO mode level tracking
    fifoEn = 1; rxAtTrig = 1; tick("R5 fifo level");
    rbrRead = 1; tick("R5 fifo data shown");
    tick("R5 read ignored in fifo mode");
    rxAtTrig = 0; tick("R5 level drop");
    tick("R5 fifo cleared");
    fifoEn = 0; tick("R5 leave fifo");

    // R10 enable masking
    srcEn = 6'b111110; lineErrEvt = 1; tick("R10 masked set");
    tick("R10 hidden");
    srcEn = 6'b111111; tick("R10 unmasked");
    // R11 set and clear together
    lineErrEvt = 1; lsrRead = 1; tick("R11 set with clear");
    tick("R11 still pending");
    lsrRead = 1; tick("R4 final clear");
    modemEvt = 1; msrRead = 1; tick("R11 modem");
    tick("R11 modem kept");
    msrRead = 1; tick("R8 final clear");
    tick("R1 idle");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule